// File: doc/BRIEF.md
# Single-Wire Dimming Mode Arbiter

This block supervises one idle-high control line that doubles as power switch and dimming-mode selector for a backlight boost converter. A rising edge on the line wakes the block. The line must then stay high for a short setup time, otherwise the wake-up is discarded. From the rising edge a fixed selection window runs. Inside that window the block looks for one pattern: a long enough high phase followed by a long enough low phase. If it sees the pattern, the serial-programmed dimming mode is chosen. If it does not, the analog-duty mode is chosen. The choice is made again at every power-up.

Once the window closes, a fixed start delay runs and then the converter enable rises, in either mode. The block shuts down when the line stays low continuously for a long time. It also shuts down on a protection-fault pulse. After a fault it stays off until the line shows a new rising edge. All durations are counted in ticks of a free-running microsecond strobe. The raw line passes through a two-stage synchronizer before any timer sees it.

Top module: `swire_mode_arbiter`

## Requirements
- R1: After reset, `conv_en`, `mode_serial` and `rx_en` are 0 and the block is in shutdown.
- R2: In shutdown, a rising edge of the synchronized line starts a power-up. If the line falls before SETUP_T ticks of high time have been counted, the block returns to shutdown and no output asserts.
- R3: The serial pattern is recognised when two conditions hold inside the window. First, the line stays high for at least HI_MIN_T ticks from the rising edge. Second, it then stays low for at least LO_HOLD_T ticks. `rx_en` asserts as soon as the pattern is recognised, even before the window closes.
- R4: When WIN_T ticks have been counted from the power-up edge, `mode_serial` takes its value: 1 if the pattern was recognised, 0 (duty mode) otherwise. A high phase shorter than HI_MIN_T or a low phase shorter than LO_HOLD_T gives duty mode. Every power-up decides afresh.
- R5: `rx_en` is 1 only in serial mode, from the moment the pattern is recognised until shutdown. It stays 0 throughout duty mode.
- R6: `conv_en` rises START_DLY_T ticks after the window closes, in both modes, and stays high until shutdown.
- R7: When the line is low for OFF_T consecutive ticks in any active state, the block shuts down. A low stretch that a high interrupts restarts this count.
- R8: A one-cycle `fault_p` in any active state causes shutdown on the next clock. The block then stays off while the line remains high, until a new rising edge. `fault_p` has no effect in shutdown.
- R9: In shutdown, `mode_serial` and `rx_en` are 0 and every timer is cleared.
- R10: Timers advance only on cycles where `tick_us` is 1. With the tick stopped, no power-up ever reaches `conv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle timebase strobe; all durations count these |
| ctl_pin | input | 1 | Raw idle-high control line (asynchronous) |
| fault_p | input | 1 | One-cycle protection-fault pulse |
| conv_en | output | 1 | Boost converter enable |
| mode_serial | output | 1 | Dimming mode: 1 serial-programmed, 0 duty |
| rx_en | output | 1 | Enable for the serial bit receiver |

## Verification
The assertions assume the following about the inputs:
- `fault_p` and `tick_us` are synchronous single-cycle strobes.
- The parameters are ordered SETUP_T ≤ HI_MIN_T and HI_MIN_T + LO_HOLD_T < WIN_T < OFF_T.

The stimulus drives every input on the falling clock edge and uses timing parameters that keep this ordering. The control line is held at each level for many cycles, so that the synchronizer delay shifts events by a fixed two cycles. The tick toggles every other cycle, and it is stopped only in the one scenario that checks the clock enable.

// File: rtl/swa_pkg.sv
package swa_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_WIN = 2'd1,
    ST_DLY = 2'd2,
    ST_RUN = 2'd3
  } arb_state_t;

  typedef enum logic [1:0] {
    PH_HI   = 2'd0,
    PH_LO   = 2'd1,
    PH_DET  = 2'd2,
    PH_FAIL = 2'd3
  } sel_phase_t;

  function automatic int cnt_w(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swa_sync.sv
module swa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d[0] = d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_comb begin
      sh_d[g] = sh_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/swa_sat_timer.sv
module swa_sat_timer #(
  parameter int LIMIT = 1,
  parameter int W     = swa_pkg::cnt_w(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LIM_C = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i & (cnt_q < LIM_C));
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(cnt_q));

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LIM_C));
endmodule

// File: rtl/swa_ctrl.sv
module swa_ctrl
  import swa_pkg::*;
#(
  parameter int SETUP_T     = 2,
  parameter int HI_MIN_T    = 100,
  parameter int LO_HOLD_T   = 260,
  parameter int WIN_T       = 1000,
  parameter int START_DLY_T = 2000,
  parameter int OFF_T       = 8900,
  parameter int HI_W        = cnt_w(max2(SETUP_T, HI_MIN_T)),
  parameter int LO_W        = cnt_w(LO_HOLD_T),
  parameter int WIN_W       = cnt_w(WIN_T),
  parameter int DLY_W       = cnt_w(START_DLY_T),
  parameter int OFF_W       = cnt_w(OFF_T)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic             fault_i,
  input  logic [HI_W-1:0]  hi_cnt_i,
  input  logic [LO_W-1:0]  lo_cnt_i,
  input  logic [WIN_W-1:0] win_cnt_i,
  input  logic [DLY_W-1:0] dly_cnt_i,
  input  logic [OFF_W-1:0] off_cnt_i,
  output logic             hi_clr_o,
  output logic             hi_inc_o,
  output logic             lo_clr_o,
  output logic             lo_inc_o,
  output logic             win_clr_o,
  output logic             win_inc_o,
  output logic             dly_clr_o,
  output logic             dly_inc_o,
  output logic             off_clr_o,
  output logic             off_inc_o,
  output logic             conv_en_o,
  output logic             mode_o,
  output logic             rx_en_o
);
  localparam logic [HI_W-1:0]  SETUP_C = HI_W'(SETUP_T);
  localparam logic [HI_W-1:0]  HIMIN_C = HI_W'(HI_MIN_T);
  localparam logic [LO_W-1:0]  LOHLD_C = LO_W'(LO_HOLD_T);
  localparam logic [WIN_W-1:0] WIN_C   = WIN_W'(WIN_T);
  localparam logic [DLY_W-1:0] DLY_C   = DLY_W'(START_DLY_T);
  localparam logic [OFF_W-1:0] OFF_C   = OFF_W'(OFF_T);

  arb_state_t st_q, st_d;
  sel_phase_t ph_q, ph_d;
  logic       mode_q, mode_d;
  logic       prev_q;
  logic       rise;

  assign rise = sync_i & ~prev_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    mode_d = mode_q;
    case (st_q)
      ST_OFF: begin
        if (rise) st_d = ST_WIN;
      end
      ST_WIN: begin
        case (ph_q)
          PH_HI: begin
            if (!sync_i) begin
              if (hi_cnt_i < SETUP_C) begin
                st_d = ST_OFF;
              end else if (hi_cnt_i >= HIMIN_C) begin
                ph_d = PH_LO;
              end else begin
                ph_d = PH_FAIL;
              end
            end
          end
          PH_LO: begin
            if (lo_cnt_i >= LOHLD_C) begin
              ph_d = PH_DET;
            end else if (sync_i) begin
              ph_d = PH_FAIL;
            end
          end
          default: ;
        endcase
        if ((win_cnt_i >= WIN_C) && (st_d == ST_WIN)) begin
          st_d   = ST_DLY;
          mode_d = (ph_q == PH_DET);
        end
      end
      ST_DLY: begin
        if (dly_cnt_i >= DLY_C) st_d = ST_RUN;
      end
      default: ;
    endcase
    if (st_q != ST_OFF) begin
      if (off_cnt_i >= OFF_C) st_d = ST_OFF;
      if (fault_i) st_d = ST_OFF;
    end
    if (st_d == ST_OFF) begin
      mode_d = 1'b0;
      ph_d   = PH_HI;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      ph_q   <= PH_HI;
      mode_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      mode_q <= mode_d;
      prev_q <= sync_i;
    end
  end

  // timer controls
  always_comb begin
    win_clr_o = (st_q != ST_WIN);
    win_inc_o = tick_i;
    hi_clr_o  = (st_q != ST_WIN);
    hi_inc_o  = tick_i & sync_i & (ph_q == PH_HI);
    lo_clr_o  = (st_q != ST_WIN) | (ph_q != PH_LO);
    lo_inc_o  = tick_i & ~sync_i;
    dly_clr_o = (st_q != ST_DLY);
    dly_inc_o = tick_i;
    off_clr_o = (st_q == ST_OFF) | sync_i;
    off_inc_o = tick_i;
  end

  assign conv_en_o = (st_q == ST_RUN);
  assign mode_o    = mode_q;
  assign rx_en_o   = mode_q | ((st_q == ST_WIN) && (ph_q == PH_DET));

  p_start_after_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_en_o) |-> ($past(st_q) == ST_DLY && $past(dly_cnt_i) >= DLY_C));

  p_mode_at_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o) |-> ($past(st_q) == ST_WIN && $past(win_cnt_i) >= WIN_C));

  p_rx_after_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en_o) |-> ($past(lo_cnt_i) >= LOHLD_C));

  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && st_q != ST_OFF) |=> (st_q == ST_OFF && !conv_en_o));

  p_long_low_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_OFF && off_cnt_i >= OFF_C) |=> (st_q == ST_OFF));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |-> (!mode_o && !rx_en_o && !conv_en_o));
endmodule

// File: rtl/swire_mode_arbiter.sv
module swire_mode_arbiter
  import swa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_T     = 2,
  parameter int HI_MIN_T    = 100,
  parameter int LO_HOLD_T   = 260,
  parameter int WIN_T       = 1000,
  parameter int START_DLY_T = 2000,
  parameter int OFF_T       = 8900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic ctl_pin,
  input  logic fault_p,
  output logic conv_en,
  output logic mode_serial,
  output logic rx_en
);
  localparam int HI_LIM = max2(SETUP_T, HI_MIN_T);
  localparam int HI_W   = cnt_w(HI_LIM);
  localparam int LO_W   = cnt_w(LO_HOLD_T);
  localparam int WIN_W  = cnt_w(WIN_T);
  localparam int DLY_W  = cnt_w(START_DLY_T);
  localparam int OFF_W  = cnt_w(OFF_T);

  logic             pin_s;
  logic [HI_W-1:0]  hi_cnt;
  logic [LO_W-1:0]  lo_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic [DLY_W-1:0] dly_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic hi_clr, hi_inc, lo_clr, lo_inc, win_clr, win_inc;
  logic dly_clr, dly_inc, off_clr, off_inc;

  swa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_pin), .q_o(pin_s)
  );

  swa_sat_timer #(.LIMIT(HI_LIM), .W(HI_W)) u_hi_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(hi_clr), .inc_i(hi_inc), .cnt_o(hi_cnt)
  );

  swa_sat_timer #(.LIMIT(LO_HOLD_T), .W(LO_W)) u_lo_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(lo_clr), .inc_i(lo_inc), .cnt_o(lo_cnt)
  );

  swa_sat_timer #(.LIMIT(WIN_T), .W(WIN_W)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(win_clr), .inc_i(win_inc), .cnt_o(win_cnt)
  );

  swa_sat_timer #(.LIMIT(START_DLY_T), .W(DLY_W)) u_dly_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(dly_clr), .inc_i(dly_inc), .cnt_o(dly_cnt)
  );

  swa_sat_timer #(.LIMIT(OFF_T), .W(OFF_W)) u_off_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(off_clr), .inc_i(off_inc), .cnt_o(off_cnt)
  );

  swa_ctrl #(
    .SETUP_T(SETUP_T), .HI_MIN_T(HI_MIN_T), .LO_HOLD_T(LO_HOLD_T),
    .WIN_T(WIN_T), .START_DLY_T(START_DLY_T), .OFF_T(OFF_T),
    .HI_W(HI_W), .LO_W(LO_W), .WIN_W(WIN_W), .DLY_W(DLY_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_us), .sync_i(pin_s), .fault_i(fault_p),
    .hi_cnt_i(hi_cnt), .lo_cnt_i(lo_cnt), .win_cnt_i(win_cnt),
    .dly_cnt_i(dly_cnt), .off_cnt_i(off_cnt),
    .hi_clr_o(hi_clr), .hi_inc_o(hi_inc), .lo_clr_o(lo_clr), .lo_inc_o(lo_inc),
    .win_clr_o(win_clr), .win_inc_o(win_inc), .dly_clr_o(dly_clr), .dly_inc_o(dly_inc),
    .off_clr_o(off_clr), .off_inc_o(off_inc),
    .conv_en_o(conv_en), .mode_o(mode_serial), .rx_en_o(rx_en)
  );
endmodule

// File: tb/test_swire_mode_arbiter.sv
module test_swire_mode_arbiter;
  localparam int SETUP_T = 2, HI_MIN_T = 10, LO_HOLD_T = 26;
  localparam int WIN_T = 100, START_DLY_T = 20, OFF_T = 200;
  localparam int S_OFF = 0, S_WIN = 1, S_DLY = 2, S_RUN = 3;
  localparam int P_HI = 0, P_LO = 1, P_DET = 2, P_FAIL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic pin = 1'b0;
  logic fault = 1'b0;
  logic tick_en = 1'b1;
  logic conv_en, mode_serial, rx_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swire_mode_arbiter #(
    .SETUP_T(SETUP_T), .HI_MIN_T(HI_MIN_T), .LO_HOLD_T(LO_HOLD_T),
    .WIN_T(WIN_T), .START_DLY_T(START_DLY_T), .OFF_T(OFF_T)
  ) i_swire_mode_arbiter (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .ctl_pin(pin), .fault_p(fault),
    .conv_en(conv_en), .mode_serial(mode_serial), .rx_en(rx_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference model
  int m_st, m_ph, m_mode, m_win, m_hi, m_lo, m_dly, m_off;
  bit m_s1, m_s, m_sp;

  function automatic int step(input int c, input bit clr, input bit inc, input int lim);
    if (clr) return 0;
    if (inc && c < lim) return c + 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = S_OFF; m_ph = P_HI; m_mode = 0;
      m_win = 0; m_hi = 0; m_lo = 0; m_dly = 0; m_off = 0;
      m_s1 = 0; m_s = 0; m_sp = 0;
    end else begin
      int nst, nph, nmode;
      nst = m_st; nph = m_ph; nmode = m_mode;
      if (m_st == S_OFF) begin
        if (m_s && !m_sp) nst = S_WIN;
      end else begin
        if (m_st == S_WIN) begin
          if (m_ph == P_HI && !m_s) begin
            if (m_hi < SETUP_T) nst = S_OFF;
            else if (m_hi >= HI_MIN_T) nph = P_LO;
            else nph = P_FAIL;
          end else if (m_ph == P_LO) begin
            if (m_lo >= LO_HOLD_T) nph = P_DET;
            else if (m_s) nph = P_FAIL;
          end
          if (m_win >= WIN_T && nst == S_WIN) begin
            nst = S_DLY;
            nmode = (m_ph == P_DET) ? 1 : 0;
          end
        end else if (m_st == S_DLY && m_dly >= START_DLY_T) begin
          nst = S_RUN;
        end
        if (m_off >= OFF_T) nst = S_OFF;
        if (fault) nst = S_OFF;
      end
      if (nst == S_OFF) begin nmode = 0; nph = P_HI; end
      m_win = step(m_win, m_st != S_WIN, tick, WIN_T);
      m_hi  = step(m_hi, m_st != S_WIN, tick && m_s && m_ph == P_HI,
                   (SETUP_T > HI_MIN_T) ? SETUP_T : HI_MIN_T);
      m_lo  = step(m_lo, m_st != S_WIN || m_ph != P_LO, tick && !m_s, LO_HOLD_T);
      m_dly = step(m_dly, m_st != S_DLY, tick, START_DLY_T);
      m_off = step(m_off, m_st == S_OFF || m_s, tick, OFF_T);
      m_st = nst; m_ph = nph; m_mode = nmode;
      m_sp = m_s; m_s = m_s1; m_s1 = pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 conv_en vs model", conv_en, m_st == S_RUN);
      chk("R4 mode_serial vs model", mode_serial, m_mode == 1);
      chk("R5 rx_en vs model", rx_en, (m_mode == 1) || (m_st == S_WIN && m_ph == P_DET));
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      tick = tick_en ? ~tick : 1'b0;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_off();
    pin = 1'b0;
    hold(440);
    chk("R7 long low shuts down", conv_en, 1'b0);
    chk("R9 mode cleared in shutdown", mode_serial, 1'b0);
    chk("R9 rx_en cleared in shutdown", rx_en, 1'b0);
  endtask

  initial begin
    hold(5);
    rst_n = 1'b1;
    chk("R1 reset conv_en", conv_en, 1'b0);
    chk("R1 reset mode", mode_serial, 1'b0);
    chk("R1 reset rx_en", rx_en, 1'b0);
    hold(20);
    chk("R1 idle low stays off", conv_en, 1'b0);

    // R2: high too short for setup -> aborted
    pin = 1'b1; hold(1); pin = 1'b0;
    hold(400);
    chk("R2 aborted startup conv_en", conv_en, 1'b0);
    chk("R2 aborted startup mode", mode_serial, 1'b0);

    // duty-mode power-up
    pin = 1'b1; hold(230);
    chk("R6 no enable before delay", conv_en, 1'b0);
    hold(40);
    chk("R6 enable after window and delay", conv_en, 1'b1);
    chk("R4 duty mode by default", mode_serial, 1'b0);
    chk("R5 rx_en off in duty", rx_en, 1'b0);

    // R7: interrupted lows do not shut down
    pin = 1'b0; hold(300); pin = 1'b1; hold(10); pin = 1'b0; hold(300); pin = 1'b1;
    hold(5);
    chk("R7 interrupted low keeps running", conv_en, 1'b1);
    power_off();

    // serial power-up
    pin = 1'b1; hold(60); pin = 1'b0; hold(80); pin = 1'b1;
    hold(10);
    chk("R3 rx_en on pattern detection", rx_en, 1'b1);
    chk("R4 mode not yet set inside window", mode_serial, 1'b0);
    hold(120);
    chk("R4 serial mode after window", mode_serial, 1'b1);
    chk("R6 enable in serial mode", conv_en, 1'b1);
    chk("R5 rx_en held in serial mode", rx_en, 1'b1);

    // R8: fault while running, line stays high
    fault = 1'b1; hold(1); fault = 1'b0; hold(3);
    chk("R8 fault shuts down", conv_en, 1'b0);
    chk("R9 fault clears mode", mode_serial, 1'b0);
    chk("R9 fault clears rx_en", rx_en, 1'b0);
    hold(600);
    chk("R8 stays off while line high", conv_en, 1'b0);
    pin = 1'b0; hold(20); pin = 1'b1; hold(270);
    chk("R8 fresh edge restarts", conv_en, 1'b1);
    chk("R4 mode re-decided as duty", mode_serial, 1'b0);
    power_off();

    // R4: high phase too short
    pin = 1'b1; hold(12); pin = 1'b0; hold(80); pin = 1'b1; hold(270);
    chk("R4 short high gives duty", mode_serial, 1'b0);
    chk("R5 short high no rx_en", rx_en, 1'b0);
    chk("R6 short high still enables", conv_en, 1'b1);
    power_off();

    // R4: low phase too short
    pin = 1'b1; hold(60); pin = 1'b0; hold(20); pin = 1'b1; hold(270);
    chk("R4 short low gives duty", mode_serial, 1'b0);
    chk("R5 short low no rx_en", rx_en, 1'b0);
    power_off();

    // R10: no tick, no progress
    tick_en = 1'b0;
    pin = 1'b1; hold(600);
    chk("R10 stalled tick holds enable off", conv_en, 1'b0);
    tick_en = 1'b1; hold(270);
    chk("R10 resumed tick enables", conv_en, 1'b1);
    power_off();

    // R8: fault in shutdown ignored
    fault = 1'b1; hold(1); fault = 1'b0; hold(5);
    pin = 1'b1; hold(270);
    chk("R8 fault in shutdown ignored", conv_en, 1'b1);

    hold(10);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule